// File: doc/BRIEF.md
# Result capture register with ready flag

This block sits between a logic block that produces result words now and then and a processor that polls for them. When the producer delivers a word, the block stores it and raises a ready flag. The stored word is then held unchanged until software acknowledges it. Software can therefore read the word at any time without seeing it change part-way through a read.

Software acknowledges a word by writing a 1 to the ready bit of the status register. A read never changes any state, so status and result can be read for diagnostics as often as needed. A word that arrives while the previous one is still unacknowledged is dropped, and an overrun bit records the loss. An interrupt output, gated by an enable bit, can be used in place of polling.

The producer may run in another clock domain. In that case its strobe passes through a chain of flip-flops, and only the rising edge of the synchronised strobe counts as a delivery. In this mode the producer must hold its data word stable until the delivery has been taken.

Top module: `result_capture`

## Requirements
- R1: A synchronous active-high reset clears the ready, overrun and interrupt-enable bits, zeroes the stored result and the read data, and drives the interrupt output low.
- R2: A delivery taken while ready is 0 stores the producer word and sets ready. Bus offset 0 reads the stored result. Bus offset 1 reads status, with ready at bit 0, overrun at bit 1, interrupt enable at bit 2 and all higher bits zero. Read data is registered: it appears after the clock edge at which the read strobe is sampled.
- R3: While ready is 1 and no clear of ready is written, the stored result does not change, whatever the producer does.
- R4: A delivery that arrives while ready is 1, with no clear of ready in the same cycle, is discarded and sets overrun. When a write that clears overrun falls in the same cycle as such a delivery, overrun stays set.
- R5: A write to offset 1 clears ready if bit 0 of the written word is 1, and clears overrun if bit 1 is 1. A written 0 in either position leaves that bit unchanged.
- R6: Reads of either offset change no flag and no stored value.
- R7: When a write that clears ready and a delivery fall in the same cycle, the new word is stored and ready stays 1.
- R8: Bit 2 of offset 1 is the interrupt enable, which is read/write. The interrupt output is a register that takes ready AND enable, so it follows them one cycle later.
- R9: Writes to offset 0 have no effect.
- R10: With the synchroniser enabled, the strobe passes through SYNC_STAGES flip-flops, and each rising edge after them yields exactly one delivery. A strobe held high for many cycles delivers once. The interrupt output rises SYNC_STAGES+2 edges after the strobe is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prod_valid | input | 1 | Producer delivery strobe |
| prod_data | input | DATA_W | Producer result word |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt: ready AND enable, registered |

## Verification
The delicate case is a producer delivery landing in the same cycle as a status write that clears ready, overrun, or both. The bench provokes this by driving the delivery and the write in one cycle. It sweeps every written value of the three status bits against every prior state: empty, ready, or ready with overrun, each with and without a delivery. It then reads status, result and the interrupt back, and compares them with values derived arithmetically from the priority rules in R4, R5 and R7.

// File: rtl/rcap_pkg.sv
package rcap_pkg;
  localparam int BIT_READY  = 0;
  localparam int BIT_OVR    = 1;
  localparam int BIT_IE     = 2;
  localparam int STATUS_W   = 3;
  localparam int OFS_RESULT = 0;
  localparam int OFS_STATUS = 1;

  typedef struct packed {
    logic ie;
    logic ovr;
    logic ready;
  } status_t;
endpackage

// File: rtl/rcap_sync.sv
module rcap_sync #(
  parameter bit SYNC_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic evt_o
);
  generate
    if (SYNC_EN) begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      logic                   last_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q <= '0;
          last_q  <= 1'b0;
        end else begin
          chain_q <= {chain_q[SYNC_STAGES-2:0], strobe_i};
          last_q  <= chain_q[SYNC_STAGES-1];
        end
      end

      assign evt_o = chain_q[SYNC_STAGES-1] & ~last_q;

      // edge detect: one delivery per rising edge
      assert_single_event_R10: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> !evt_o);
    end else begin : g_bypass
      logic unused_sync;
      assign unused_sync = clk ^ rst;
      assign evt_o       = strobe_i;
    end
  endgenerate
endmodule

// File: rtl/rcap_hold.sv
module rcap_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_clr_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ready_o,
  output logic              ovr_o
);
  logic accept;
  logic lost;

  assign accept = evt_i & (~ready_o | ready_clr_i);
  assign lost   = evt_i & ready_o & ~ready_clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ready_o  <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      if (accept) result_o <= data_i;
      if (accept)           ready_o <= 1'b1;
      else if (ready_clr_i) ready_o <= 1'b0;
      if (lost)             ovr_o <= 1'b1;
      else if (ovr_clr_i)   ovr_o <= 1'b0;
    end
  end

  assert_result_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !ready_clr_i) |=> $stable(result_o));

  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_i && ready_o && !ready_clr_i) |=> ovr_o);

  assert_clear_and_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_i && ready_clr_i) |=> (ready_o && result_o == $past(data_i)));
endmodule

// File: rtl/rcap_regs.sv
module rcap_regs
  import rcap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              ready_i,
  input  logic              ovr_i,
  output logic              ready_clr_o,
  output logic              ovr_clr_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic    sel_status;
  logic    sel_result;
  logic    wr_status;
  status_t st;
  logic    unused_wdata;

  assign sel_status   = (addr_i == ADDR_W'(OFS_STATUS));
  assign sel_result   = (addr_i == ADDR_W'(OFS_RESULT));
  assign wr_status    = wr_i & sel_status;
  assign ready_clr_o  = wr_status & wdata_i[BIT_READY];
  assign ovr_clr_o    = wr_status & wdata_i[BIT_OVR];
  assign unused_wdata = ^wdata_i[DATA_W-1:STATUS_W];

  always_comb begin
    st.ie    = ie_o;
    st.ovr   = ovr_i;
    st.ready = ready_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_o    <= 1'b0;
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (wr_status) ie_o <= wdata_i[BIT_IE];
      if (rd_i) begin
        if (sel_status)      rdata_o <= {{(DATA_W-STATUS_W){1'b0}}, st};
        else if (sel_result) rdata_o <= result_i;
        else                 rdata_o <= '0;
      end
      irq_o <= ready_i & ie_o;
    end
  end

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (ready_i && ie_o) |=> irq_o);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !ie_o |=> !irq_o);
endmodule

// File: rtl/result_capture.sv
module result_capture
  import rcap_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 1,
  parameter bit SYNC_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prod_valid,
  input  logic [DATA_W-1:0] prod_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              evt;
  logic              ready;
  logic              ovr;
  logic              ie;
  logic              ready_clr;
  logic              ovr_clr;
  logic [DATA_W-1:0] result;

  rcap_sync #(.SYNC_EN(SYNC_EN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_i(prod_valid), .evt_o(evt)
  );

  rcap_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .evt_i(evt), .data_i(prod_data),
    .ready_clr_i(ready_clr), .ovr_clr_i(ovr_clr),
    .result_o(result), .ready_o(ready), .ovr_o(ovr)
  );

  rcap_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .rd_i(bus_rd), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .result_i(result), .ready_i(ready), .ovr_i(ovr),
    .ready_clr_o(ready_clr), .ovr_clr_o(ovr_clr), .ie_o(ie),
    .rdata_o(bus_rdata), .irq_o(irq)
  );

  assert_read_no_side_effect_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !evt) |=>
      ($stable(ready) && $stable(ovr) && $stable(ie) && $stable(result)));

  assert_write_zero_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_STATUS) && !bus_wdata[BIT_READY] && ready) |=> ready);

  assert_result_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_RESULT) && !evt) |=>
      ($stable(ready) && $stable(ovr) && $stable(ie) && $stable(result)));
endmodule

// File: tb/sim_result_capture.sv
module sim_result_capture;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic valid = 1'b0;
  logic [DW-1:0] data = '0;
  logic addr = 1'b0;
  logic rd = 1'b0;
  logic wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata0, rdata1;
  logic irq0, irq1;
  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_capture #(.DATA_W(DW), .ADDR_W(1), .SYNC_EN(1'b0), .SYNC_STAGES(SS)) u0 (
    .clk(clk), .rst(rst), .prod_valid(valid & ~sel), .prod_data(data),
    .bus_addr(addr), .bus_rd(rd & ~sel), .bus_wr(wr & ~sel), .bus_wdata(wdata),
    .bus_rdata(rdata0), .irq(irq0)
  );

  result_capture #(.DATA_W(DW), .ADDR_W(1), .SYNC_EN(1'b1), .SYNC_STAGES(SS)) u1 (
    .clk(clk), .rst(rst), .prod_valid(valid & sel), .prod_data(data),
    .bus_addr(addr), .bus_rd(rd & sel), .bus_wr(wr & sel), .bus_wdata(wdata),
    .bus_rdata(rdata1), .irq(irq1)
  );

  function automatic logic cur_irq();
    return sel ? irq1 : irq0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic do_read(input logic a, output logic [DW-1:0] v);
    @(negedge clk) begin addr = a; rd = 1'b1; end
    @(posedge clk); #1;
    v = sel ? rdata1 : rdata0;
    rd = 1'b0;
  endtask

  task automatic do_write(input logic a, input logic [DW-1:0] v);
    @(negedge clk) begin addr = a; wdata = v; wr = 1'b1; end
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic deliver(input logic [DW-1:0] d);
    @(negedge clk) begin data = d; valid = 1'b1; end
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  task automatic combo(input logic [DW-1:0] d, input logic v, input logic [2:0] w);
    @(negedge clk) begin
      data = d; valid = v; addr = 1'b1; wdata = DW'(w); wr = 1'b1;
    end
    @(posedge clk); #1;
    valid = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    do_reset();

    // R1 reset state
    check("R1 irq", irq0, 0);
    do_read(1'b1, v); check("R1 status", v, 0);
    do_read(1'b0, v); check("R1 result", v, 0);

    // R2 capture
    deliver(16'h1234);
    do_read(1'b0, v); check("R2 result", v, 16'h1234);
    do_read(1'b1, v); check("R2 status", v, 1);

    // R3/R4 frozen while ready, overrun recorded
    for (int i = 0; i < 5; i++) deliver(DW'(16'h4000 + i * 7));
    do_read(1'b0, v); check("R3 frozen", v, 16'h1234);
    do_read(1'b1, v); check("R4 overrun", v, 3);

    // R6 repeated reads
    for (int i = 0; i < 3; i++) begin
      do_read(1'b1, v); check("R6 status read", v, 3);
      do_read(1'b0, v); check("R6 result read", v, 16'h1234);
    end

    // R9 write to result offset ignored
    do_write(1'b0, 16'hffff);
    do_read(1'b0, v); check("R9 result", v, 16'h1234);
    do_read(1'b1, v); check("R9 status", v, 3);

    // R5 write-one-to-clear
    do_write(1'b1, 16'h0000);
    do_read(1'b1, v); check("R5 zero write", v, 3);
    do_write(1'b1, 16'h0002);
    do_read(1'b1, v); check("R5 clear ovr", v, 1);
    do_write(1'b1, 16'h0001);
    do_read(1'b1, v); check("R5 clear ready", v, 0);
    do_read(1'b0, v); check("R5 result kept", v, 16'h1234);
    deliver(16'h5a5a);
    do_read(1'b0, v); check("R2 recapture", v, 16'h5a5a);

    // R8 interrupt lag
    do_write(1'b1, 16'h0004);
    check("R8 irq lag", irq0, 0);
    @(posedge clk); #1;
    check("R8 irq high", irq0, 1);
    do_read(1'b1, v); check("R8 ie readback", v, 5);
    do_write(1'b1, 16'h0005);
    check("R8 irq holds one cycle", irq0, 1);
    @(posedge clk); #1;
    check("R8 irq low", irq0, 0);

    // R4/R5/R7 sweep of same-cycle delivery and status write
    for (int p = 0; p < 2; p++)
      for (int o = 0; o <= p; o++)
        for (int vv = 0; vv < 2; vv++)
          for (int w = 0; w < 8; w++) begin
            logic [DW-1:0] a, b, er;
            logic clr, acc, er_rdy, er_ovr, er_ie;
            a = DW'(37 * w + 101 * p + 5);
            b = ~a;
            do_reset();
            if (p != 0) deliver(a);
            if (o != 0) deliver(a ^ 16'h00ff);
            combo(b, vv[0], w[2:0]);
            check("R8 sweep lag", irq0, 0);
            clr    = w[0];
            acc    = vv[0] && (p == 0 || clr);
            er_rdy = acc || (p != 0 && !clr);
            er_ovr = (vv[0] && p != 0 && !clr) || (o != 0 && !w[1]);
            er_ie  = w[2];
            er     = acc ? b : (p != 0 ? a : '0);
            do_read(1'b1, v);
            check("R4/R5/R7 sweep status", v, {er_ie, er_ovr, er_rdy});
            do_read(1'b0, v);
            check("R7 sweep result", v, er);
            check("R8 sweep irq", irq0, er_rdy & er_ie);
          end

    // R10 synchronised producer
    sel = 1'b1;
    do_reset();
    do_write(1'b1, 16'h0004);
    @(negedge clk) begin data = 16'habcd; valid = 1'b1; end
    for (int e = 1; e <= 8; e++) begin
      @(posedge clk); #1;
      check("R10 irq latency", cur_irq(), (e >= SS + 2) ? 1 : 0);
    end
    do_read(1'b0, v); check("R10 result", v, 16'habcd);
    do_write(1'b1, 16'h0005);
    repeat (4) @(posedge clk);
    #1;
    do_read(1'b1, v); check("R10 held strobe single delivery", v, 4);
    @(negedge clk) valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    do_read(1'b1, v); check("R10 falling edge no delivery", v, 4);
    sel = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule